// File: doc/BRIEF.md
# Test-Access-Port User Register File

This block is a register file that a host reaches through one user data register on a test-access port. The test-access port state machine outside the block decodes its own states and supplies capture, shift and update strobes, with TDI and TDO, all timed by TCK. A select input says that the user instruction is currently loaded. While select is high, each data-register scan shifts a frame into a shift chain, least significant bit first. At update time the frame is decoded by its length and its write flag, and its parity is checked.

A long frame writes one of sixteen 32-bit registers. A short frame asks for a read. It latches the addressed value, and the host shifts that value out during the next data-register scan. Reading the result address pops a result FIFO instead of a register. The compute core fills that FIFO with words delivered on TCK. Eight job state words, three job data words and a clock setting word are driven out continuously. A write to the last job data word raises a one-cycle start pulse in the system clock domain, carried across by a toggle synchronizer.

Top module: `jtag_user_regfile`

## Requirements
- R1: A 38-bit frame is a write when bit 36 (write flag) is 1 and the XOR of all 38 bits is 1. Bits 31:0 hold the data and bits 35:32 hold the address. At update the addressed register takes the data.
- R2: A write-length frame whose XOR over all 38 bits is 0 changes no register.
- R3: A frame of any length other than 38 or 6 bits changes no register and loads no read result. A 38-bit frame with flag 0 does the same, and so does a 6-bit frame with flag 1.
- R4: A 6-bit frame is a read request when bits 3:0 hold the address, bit 4 is 0, and the XOR of the six bits is 1. The addressed value is shifted out on TDO during the next scan, least significant bit first, one bit per shift cycle.
- R5: A read of address 14 returns the oldest word pushed by res_valid/res_word and removes it, so words come back in push order.
- R6: A read of address 14 while the FIFO is empty returns 0xFFFFFFFF.
- R7: The FIFO holds 16 words. A push while it is full is discarded, and fifo_overflow is set and stays high until reset.
- R8: A valid write to address 11 produces exactly one system-clock cycle of job_start. Writes to other addresses produce none.
- R9: job_state carries registers 1 to 8 (register 1 in bits 31:0), job_data carries registers 9 to 11 (register 9 in bits 31:0), and clk_setting carries register 13.
- R10: After reset every register reads 0, the FIFO is empty, fifo_overflow is 0 and job_start is 0.
- R11: While sel is 0, capture, shift and update strobes leave registers and the pending read result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the job-start pulse |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| tck | input | 1 | Test clock |
| sel | input | 1 | User instruction is selected |
| capture | input | 1 | Capture-DR strobe |
| shift | input | 1 | Shift-DR strobe |
| update | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| res_valid | input | 1 | Push strobe for the result FIFO (TCK domain) |
| res_word | input | 32 | Result word to push |
| job_state | output | 256 | Registers 1 to 8 |
| job_data | output | 96 | Registers 9 to 11 |
| clk_setting | output | 32 | Register 13 |
| job_start | output | 1 | One-cycle job start pulse (clk domain) |
| fifo_overflow | output | 1 | Sticky flag for a dropped push |

## Verification
The bench builds the block with its defaults: 32-bit words, a 4-bit address, 16 FIFO entries and two synchronizer stages. With these values the 38-bit and 6-bit frame lengths are reached, and so is the boundary where the seventeenth push overflows. Random writes carry good parity, and random pushes and pops are kept short of full, so the register bank and FIFO ordering are compared against a bench model. Directed scans then bring in bad parity, wrong lengths, mismatched flags, a deselected tap, the empty read and the overflow.

// File: rtl/jtag_user_regfile.sv
module jtag_user_regfile #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2,
  parameter int JOB_FIRST   = 1,
  parameter int JOB_WORDS   = 8,
  parameter int DATA_WORDS  = 3,
  parameter int CLK_ADDR    = 13,
  parameter int RES_ADDR    = 14
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tck,
  input  logic                         sel,
  input  logic                         capture,
  input  logic                         shift,
  input  logic                         update,
  input  logic                         tdi,
  output logic                         tdo,
  input  logic                         res_valid,
  input  logic [DATA_W-1:0]            res_word,
  output logic [JOB_WORDS*DATA_W-1:0]  job_state,
  output logic [DATA_WORDS*DATA_W-1:0] job_data,
  output logic [DATA_W-1:0]            clk_setting,
  output logic                         job_start,
  output logic                         fifo_overflow
);
  localparam int NREG     = 1 << ADDR_W;
  localparam int FRAME_W  = DATA_W + ADDR_W + 2;
  localparam int READ_W   = ADDR_W + 2;
  localparam int FLAG_BIT = DATA_W + ADDR_W;
  localparam int CNT_W    = $clog2(FRAME_W + 2);
  localparam int PTR_W    = $clog2(FIFO_DEPTH);
  localparam int GO_ADDR  = JOB_FIRST + JOB_WORDS + DATA_WORDS - 1;

  logic [FRAME_W-1:0] sr;
  logic [CNT_W-1:0]   cnt;
  logic [DATA_W-1:0]  regs [NREG];
  logic [DATA_W-1:0]  rd_data;
  logic [DATA_W-1:0]  fifo [FIFO_DEPTH];
  logic [PTR_W-1:0]   wp, rp;
  logic [PTR_W:0]     fcnt;
  logic               go_tgl;
  logic [SYNC_STAGES:0] sync;

  wire [ADDR_W-1:0] addr = sr[FLAG_BIT-1:DATA_W];
  wire flag   = sr[FLAG_BIT];
  wire upd    = sel && update;
  wire wr_ok  = upd && (cnt == CNT_W'(FRAME_W)) && flag && (^sr);
  wire rd_ok  = upd && (cnt == CNT_W'(READ_W)) && !flag && (^sr[FRAME_W-1:DATA_W]);
  wire f_empty = (fcnt == '0);
  wire f_full  = (fcnt == (PTR_W+1)'(FIFO_DEPTH));
  wire pop    = rd_ok && (addr == ADDR_W'(RES_ADDR)) && !f_empty;
  wire push   = res_valid && (!f_full || pop);

  assign tdo = sr[0];

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (sel && capture) begin
      sr  <= {{(FRAME_W-DATA_W){1'b0}}, rd_data};
      cnt <= '0;
    end else if (sel && shift) begin
      sr  <= {tdi, sr[FRAME_W-1:1]};
      if (cnt != '1) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      go_tgl <= 1'b0;
    end else if (wr_ok) begin
      regs[addr] <= sr[DATA_W-1:0];
      if (addr == ADDR_W'(GO_ADDR)) go_tgl <= ~go_tgl;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_ok) begin
      if (addr == ADDR_W'(RES_ADDR)) rd_data <= f_empty ? '1 : fifo[rp];
      else rd_data <= regs[addr];
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      fcnt <= '0;
      fifo_overflow <= 1'b0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      if (push && !pop) fcnt <= fcnt + 1'b1;
      else if (pop && !push) fcnt <= fcnt - 1'b1;
      if (res_valid && !push) fifo_overflow <= 1'b1;
    end
  end

  always_ff @(posedge tck) if (push) fifo[wp] <= res_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '0;
    else sync <= {sync[SYNC_STAGES-1:0], go_tgl};
  end
  assign job_start = sync[SYNC_STAGES] ^ sync[SYNC_STAGES-1];

  for (genvar g = 0; g < JOB_WORDS; g++) begin : g_state
    assign job_state[g*DATA_W +: DATA_W] = regs[JOB_FIRST+g];
  end
  for (genvar g = 0; g < DATA_WORDS; g++) begin : g_data
    assign job_data[g*DATA_W +: DATA_W] = regs[JOB_FIRST+JOB_WORDS+g];
  end
  assign clk_setting = regs[CLK_ADDR];

  p_fifo_bound_r7: assert property (@(posedge tck) disable iff (!rst_n)
    fcnt <= (PTR_W+1)'(FIFO_DEPTH));
  p_ovf_sticky_r7: assert property (@(posedge tck) disable iff (!rst_n)
    fifo_overflow |=> fifo_overflow);
  p_full_drop_r7: assert property (@(posedge tck) disable iff (!rst_n)
    (res_valid && f_full && !pop) |=> fifo_overflow && $stable(fcnt));
  p_empty_read_r6: assert property (@(posedge tck) disable iff (!rst_n)
    (rd_ok && addr == ADDR_W'(RES_ADDR) && f_empty) |=> rd_data == '1);
  p_bad_parity_r2: assert property (@(posedge tck) disable iff (!rst_n)
    (upd && cnt == CNT_W'(FRAME_W) && !(^sr)) |=>
      $stable(job_state) && $stable(job_data) && $stable(clk_setting));
  p_desel_r11: assert property (@(posedge tck) disable iff (!rst_n)
    (!sel && !res_valid) |=> $stable(rd_data) && $stable(job_state) && $stable(clk_setting));
  p_pulse_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    job_start |=> !job_start);
endmodule

// File: tb/tb_jtag_user_regfile.sv
module tb_jtag_user_regfile;
  logic clk = 0, tck = 0, rst_n = 0;
  logic sel = 1, capture = 0, shift = 0, update = 0, tdi = 0, res_valid = 0;
  logic [31:0] res_word = 0;
  logic tdo, job_start, fifo_overflow;
  logic [255:0] job_state;
  logic [95:0]  job_data;
  logic [31:0]  clk_setting;

  always #5 clk = ~clk;
  always #10 tck = ~tck;

  jtag_user_regfile dut (.clk, .rst_n, .tck, .sel, .capture, .shift, .update, .tdi, .tdo,
    .res_valid, .res_word, .job_state, .job_data, .clk_setting, .job_start, .fifo_overflow);

  int tests = 0, fails = 0, jobs = 0;
  logic [31:0] model [16];
  logic [31:0] q [64];
  int qh = 0, qt = 0;

  always @(posedge clk) if (rst_n && job_start) jobs++;

  task automatic check(string req, logic [255:0] got, logic [255:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0h exp %0h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] wframe(logic [3:0] a, logic [31:0] d, bit good);
    logic [37:0] f;
    f = {1'b0, 1'b1, a, d};
    f[37] = ~(^f[36:0]) ^ !good;
    return {26'b0, f};
  endfunction

  function automatic logic [63:0] rframe(logic [3:0] a, bit flag);
    logic [5:0] f;
    f = {1'b0, flag, a};
    f[5] = ~(^f[4:0]);
    return {58'b0, f};
  endfunction

  task automatic scan(int n, logic [63:0] din, output logic [63:0] dout);
    dout = 0;
    @(negedge tck) capture = 1;
    @(negedge tck) capture = 0; shift = 1;
    for (int i = 0; i < n; i++) begin
      tdi = din[i];
      dout[i] = tdo;
      @(negedge tck);
    end
    shift = 0; update = 1;
    @(negedge tck) update = 0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    logic [63:0] o;
    scan(38, wframe(a, d, 1), o);
    model[a] = d;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    logic [63:0] o;
    scan(6, rframe(a, 0), o);
    scan(32, 64'h0, o);
    v = o[31:0];
  endtask

  task automatic push(logic [31:0] w);
    @(negedge tck) res_valid = 1; res_word = w;
    @(negedge tck) res_valid = 0;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog got hang exp finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [63:0] o;
    int j0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) model[i] = 0;
    repeat (3) @(negedge tck);
    rst_n = 1;
    // R10 reset state
    rd(4'd5, v); check("R10 reg5", v, 0);
    rd(4'd14, v); check("R10 fifo empty", v, 32'hFFFFFFFF);
    check("R10 ovf", fifo_overflow, 0);
    check("R10 jobs", jobs, 0);
    // R1 R4 R9 random writes and readback
    for (int k = 0; k < 40; k++) begin
      logic [3:0] a;
      a = 4'($urandom_range(0, 15));
      if (a == 14 || a == 11) a = 4'd12;
      wr(a, $urandom);
    end
    for (int a = 0; a < 16; a++) if (a != 14) begin
      rd(4'(a), v); check("R1 R4 readback", v, model[a]);
    end
    wr(4'd13, 32'd190);
    check("R9 clk_setting", clk_setting, 190);
    for (int a = 1; a <= 8; a++) wr(4'(a), 32'h1000_0000 + 32'(a));
    check("R9 job_state", job_state, {model[8], model[7], model[6], model[5],
                                      model[4], model[3], model[2], model[1]});
    // R8 job start
    j0 = jobs;
    wr(4'd9, 32'hAAAA0009); wr(4'd10, 32'hBBBB000A);
    repeat (10) @(posedge clk);
    check("R8 no pulse other addr", jobs, j0);
    wr(4'd11, 32'hCCCC000B);
    repeat (10) @(posedge clk);
    check("R8 one pulse", jobs, j0 + 1);
    check("R9 job_data", job_data, {model[11], model[10], model[9]});
    // R2 bad parity
    scan(38, wframe(4'd3, 32'hDEADBEEF, 0), o);
    rd(4'd3, v); check("R2 bad parity", v, model[3]);
    j0 = jobs;
    scan(38, wframe(4'd11, 32'h1, 0), o);
    repeat (10) @(posedge clk);
    check("R2 R8 bad parity no job", jobs, j0);
    // R3 wrong length / flag mismatch
    scan(37, wframe(4'd4, 32'h12345678, 1), o);
    rd(4'd4, v); check("R3 37 bits", v, model[4]);
    scan(39, {wframe(4'd4, 32'h12345678, 1)} << 1, o);
    rd(4'd4, v); check("R3 39 bits", v, model[4]);
    o = wframe(4'd4, 32'h55, 1); o[36] = 0; o[37] = ~o[37];
    scan(38, o, o);
    rd(4'd4, v); check("R3 flag0 long", v, model[4]);
    rd(4'd2, v);
    scan(6, rframe(4'd3, 1), o);
    scan(32, 0, o); check("R3 flag1 short", o[31:0], model[2]);
    // R11 deselected
    sel = 0;
    scan(38, wframe(4'd6, 32'h0BADF00D, 1), o);
    sel = 1;
    rd(4'd6, v); check("R11 desel write", v, model[6]);
    sel = 0; scan(6, rframe(4'd7, 0), o); sel = 1;
    scan(32, 0, o); check("R11 desel read", o[31:0], model[6]);
    // R5 random fifo traffic
    for (int k = 0; k < 60; k++) begin
      if ((qt - qh) < 12 && ($urandom_range(0, 1) == 1)) begin
        q[qt % 64] = $urandom; push(q[qt % 64]); qt++;
      end else begin
        rd(4'd14, v);
        if (qt == qh) check("R6 empty", v, 32'hFFFFFFFF);
        else begin check("R5 pop order", v, q[qh % 64]); qh++; end
      end
    end
    while (qh != qt) begin rd(4'd14, v); check("R5 drain", v, q[qh % 64]); qh++; end
    rd(4'd14, v); check("R6 empty after drain", v, 32'hFFFFFFFF);
    check("R7 no overflow yet", fifo_overflow, 0);
    // R7 overflow
    for (int k = 0; k < 16; k++) push(32'h100 + 32'(k));
    check("R7 full no ovf", fifo_overflow, 0);
    push(32'hFFFF0000);
    check("R7 ovf set", fifo_overflow, 1);
    for (int k = 0; k < 16; k++) begin
      rd(4'd14, v); check("R7 kept entries", v, 32'h100 + 32'(k));
    end
    rd(4'd14, v); check("R7 dropped word", v, 32'hFFFFFFFF);
    check("R7 ovf sticky", fifo_overflow, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule